// File: doc/BRIEF.md
# Multi-Variant Subsystem Control Register Bank

This block is a 4 KB window of 32-bit control and status words for a small secure microcontroller subsystem. A static parameter picks one of three register layouts (variant A, B or C). The layouts share most words but differ in which words exist, where the CPU hold word and the NMI enable word live, and whether the boot-vector and power-control words carry lock bits.

The block accepts one word access per cycle on a simple request bus (valid, write, address, write data). Reads return data one cycle later with a valid strobe. It holds the reset cause, reset mask, retention word, boot vectors, CPU hold bits, secure-debug enables, clock-control words, power-sense words and a fixed identification block. It drives a one-cycle software-reset request, one-cycle per-CPU release pulses when a hold bit is dropped, and the boot vector for each CPU. The clock dividers, reset sequencer and power sensors themselves sit outside. Their words only keep what software writes.

Top module: `subsys_ctrl_regs`

## Requirements
- R1: A read of an offset with no word in the selected variant, of a reserved offset or of a write-only offset (0x004, 0x008, 0x108) returns 0. A write to such an offset, to 0x000 or to the identification block changes no stored state.
- R2: The secure-debug enable word reads at 0x000 and resets to 0. A write to 0x004 ORs the written bits into it, and a write to 0x008 clears each bit written as 1.
- R3: A write to 0x108 with bit 9 set raises `sw_reset_req` for exactly one cycle. A write with bit 9 clear raises nothing.
- R4: After reset: reset cause (0x100) is 1, system power sense (0x200, variants B/C) is 0x7F, power control (0x1FC, variant C) is 0x3, the hold word is `HOLD_RST`, both boot vectors are `BOOTVEC_RST`, every other word is 0, and no pulse output is high.
- R5: Boot vector 0 lives at 0x110. In variant C, once its stored bit 0 (lock) is 1, writes are dropped, and `boot_vec0` shows bits 31:7 of the word with bits 6:0 zero. In A/B every write lands, and `boot_vec0` equals the full word.
- R6: Power control at 0x1FC exists only in variant C. A write lands only while the stored bit 0 (unlock) is 1. Bit 1 is a plain stored flag.
- R7: A write to the hold word raises `cpu_release[i]` for one cycle for each checked CPU whose hold bit goes from 1 to 0. CPUs 0 and 1 are checked in A/B, and only CPU 0 in C.
- R8: The hold word is at 0x118 in A/B and at 0x120 in C. The NMI enable word is at 0x11C in B and at 0x124 in C. In C, 0x118 and 0x11C are reserved. In A/B, 0x120 is a plain wake-control word, and in B, 0x124 is a plain event-wake word.
- R9: Variant A has no words at 0x00C-0x018, 0x114, 0x124 or 0x200-0x218, and 0x11C reads 0 and ignores writes. Boot vector 1 (0x114) exists only in B. Elsewhere `boot_vec1` stays at `BOOTVEC_RST`.
- R10: Offsets 0xFD0 to 0xFFC read, in address order, 0x04,0,0,0, 0x54,0xB8,v,0, 0x0D,0xF0,0x05,0xB1, where v is 0x0B in A and 0x1B in B/C.
- R11: Sense words 0x20C/0x210 exist only in B, 0x214/0x218 exist in B and C, and 0x204 exists only in C. Each existing one reads back what was written.
- R12: Read data appears with `rd_valid` on the cycle after the read request. Address bits 1:0 are ignored, so an unaligned access targets the containing word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the bank |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| sw_reset_req | output | 1 | One-cycle software reset request |
| cpu_release | output | 2 | One-cycle per-CPU release pulses |
| boot_vec0 | output | 32 | Boot vector for CPU 0 |
| boot_vec1 | output | 32 | Boot vector for CPU 1 |

## Verification
A write is taken at the rising edge where it is presented. The stored word, `boot_vec0`/`boot_vec1`, `sw_reset_req` and `cpu_release` all change at that same edge, so the bench checks them at the falling edge that follows and checks the end of each pulse one falling edge later. A read presented at one rising edge yields `rd_valid` and data after that edge. The driver queues the expected word when it issues the read, and a monitor pops and compares it at the next falling edge whenever `rd_valid` is high. Three instances, one per variant, share the bus so that every access is checked against all three layouts.

// File: rtl/subsys_ctrl_pkg.sv
package subsys_ctrl_pkg;

  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int NUM_CPU   = 2;
  localparam int NUM_PLAIN = 16;
  localparam int SLOT_W    = $clog2(NUM_PLAIN);

  localparam int VAR_A = 0;
  localparam int VAR_B = 1;
  localparam int VAR_C = 2;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_DBG_STAT, SEL_DBG_SET, SEL_DBG_CLR, SEL_SWRST,
    SEL_VEC0, SEL_VEC1, SEL_HOLD, SEL_PWR, SEL_ID,
    SEL_SECCTL, SEL_FDIV, SEL_SDIV, SEL_CLKF, SEL_CAUSE, SEL_RMASK,
    SEL_RETAIN, SEL_NMI, SEL_WAKE, SEL_EWAKE, SEL_SNS_SYS, SEL_SNS_CPU,
    SEL_SNS_R0, SEL_SNS_R1, SEL_SNS_R2, SEL_SNS_R3
  } sel_e;

  // Storage slot of a plain read/write word, -1 when the select is not plain.
  function automatic int plain_slot(sel_e s);
    case (s)
      SEL_SECCTL:  return 0;
      SEL_FDIV:    return 1;
      SEL_SDIV:    return 2;
      SEL_CLKF:    return 3;
      SEL_CAUSE:   return 4;
      SEL_RMASK:   return 5;
      SEL_RETAIN:  return 6;
      SEL_NMI:     return 7;
      SEL_WAKE:    return 8;
      SEL_EWAKE:   return 9;
      SEL_SNS_SYS: return 10;
      SEL_SNS_CPU: return 11;
      SEL_SNS_R0:  return 12;
      SEL_SNS_R1:  return 13;
      SEL_SNS_R2:  return 14;
      SEL_SNS_R3:  return 15;
      default:     return -1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] plain_reset(int slot);
    case (slot)
      4:       return DATA_W'(32'h1);
      10:      return DATA_W'(32'h7F);
      default: return '0;
    endcase
  endfunction

  // Identification byte for entry idx (0..11) of the ID block.
  function automatic logic [DATA_W-1:0] id_value(logic [3:0] idx, int variant);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'h04;
      4'd4:    b = 8'h54;
      4'd5:    b = 8'hB8;
      4'd6:    b = (variant == VAR_A) ? 8'h0B : 8'h1B;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return {{(DATA_W-8){1'b0}}, b};
  endfunction

endpackage

// File: rtl/subsys_ctrl_decode.sv
module subsys_ctrl_decode
  import subsys_ctrl_pkg::*;
#(
  parameter int VARIANT = VAR_C
) (
  input  logic [ADDR_W-1:2] word_addr,
  output sel_e              sel
);
  localparam bit IS_A = (VARIANT == VAR_A);
  localparam bit IS_B = (VARIANT == VAR_B);
  localparam bit IS_C = (VARIANT == VAR_C);

  logic [ADDR_W-1:0] off;
  assign off = {word_addr, 2'b00};

  always_comb begin
    sel = SEL_NONE;
    case (off)
      12'h000: sel = SEL_DBG_STAT;
      12'h004: sel = SEL_DBG_SET;
      12'h008: sel = SEL_DBG_CLR;
      12'h00C: sel = IS_A ? SEL_NONE : SEL_SECCTL;
      12'h010: sel = IS_A ? SEL_NONE : SEL_FDIV;
      12'h014: sel = IS_A ? SEL_NONE : SEL_SDIV;
      12'h018: sel = IS_A ? SEL_NONE : SEL_CLKF;
      12'h100: sel = SEL_CAUSE;
      12'h104: sel = SEL_RMASK;
      12'h108: sel = SEL_SWRST;
      12'h10C: sel = SEL_RETAIN;
      12'h110: sel = SEL_VEC0;
      12'h114: sel = IS_B ? SEL_VEC1 : SEL_NONE;
      12'h118: sel = IS_C ? SEL_NONE : SEL_HOLD;
      12'h11C: sel = IS_B ? SEL_NMI : SEL_NONE;
      12'h120: sel = IS_C ? SEL_HOLD : SEL_WAKE;
      12'h124: sel = IS_A ? SEL_NONE : (IS_B ? SEL_EWAKE : SEL_NMI);
      12'h1FC: sel = IS_C ? SEL_PWR : SEL_NONE;
      12'h200: sel = IS_A ? SEL_NONE : SEL_SNS_SYS;
      12'h204: sel = IS_C ? SEL_SNS_CPU : SEL_NONE;
      12'h20C: sel = IS_B ? SEL_SNS_R0 : SEL_NONE;
      12'h210: sel = IS_B ? SEL_SNS_R1 : SEL_NONE;
      12'h214: sel = IS_A ? SEL_NONE : SEL_SNS_R2;
      12'h218: sel = IS_A ? SEL_NONE : SEL_SNS_R3;
      default: begin
        if (off[11:6] == 6'h3F && off[5:2] >= 4'd4) sel = SEL_ID;
      end
    endcase
  end

endmodule

// File: rtl/subsys_ctrl_word.sv
module subsys_ctrl_word #(
  parameter int                W   = 32,
  parameter logic [W-1:0]      RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb q_d = en ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_d;
  end

endmodule

// File: rtl/subsys_ctrl_hold.sv
module subsys_ctrl_hold #(
  parameter int              W      = 32,
  parameter int              NCPU   = 2,
  parameter int              NCHK   = 2,
  parameter logic [W-1:0]    RST    = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    hold_q,
  output logic [NCPU-1:0] release_o
);
  logic [W-1:0]    hold_d;
  logic [NCPU-1:0] release_d;

  always_comb hold_d = wr_en ? wdata : hold_q;

  generate
    for (genvar i = 0; i < NCPU; i++) begin : g_rel
      if (i < NCHK) begin : g_chk
        always_comb release_d[i] = wr_en & hold_q[i] & ~wdata[i];
      end else begin : g_off
        always_comb release_d[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= RST;
      release_o <= '0;
    end else begin
      hold_q    <= hold_d;
      release_o <= release_d;
    end
  end

  AST_RELEASE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|release_o) |-> $past(wr_en)); // R7
  AST_RELEASE_FROM_SET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|release_o) |-> ((release_o & ~$past(hold_q[NCPU-1:0])) == '0)); // R7
  AST_RELEASE_BIT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (|release_o) |-> ((release_o & hold_q[NCPU-1:0]) == '0)); // R7

endmodule

// File: rtl/subsys_ctrl_regs.sv
module subsys_ctrl_regs
  import subsys_ctrl_pkg::*;
#(
  parameter int                 VARIANT     = VAR_C,
  parameter logic [DATA_W-1:0]  HOLD_RST    = '0,
  parameter logic [DATA_W-1:0]  BOOTVEC_RST = 32'h1000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic               sw_reset_req,
  output logic [NUM_CPU-1:0] cpu_release,
  output logic [DATA_W-1:0]  boot_vec0,
  output logic [DATA_W-1:0]  boot_vec1
);
  localparam bit IS_C       = (VARIANT == VAR_C);
  localparam int NCHK       = IS_C ? 1 : NUM_CPU;
  localparam int SWRST_BIT  = 9;
  localparam int VEC_LOW    = 7;
  localparam logic [DATA_W-1:0] PWR_RST = DATA_W'(32'h3);

  sel_e              sel;
  logic              wr_en;
  logic              rd_en;
  logic              addr_lo_unused;
  int                slot;
  logic              slot_hit;
  logic [SLOT_W-1:0] slot_idx;

  assign wr_en          = req_valid &  req_write;
  assign rd_en          = req_valid & ~req_write;
  assign addr_lo_unused = ^req_addr[1:0];

  subsys_ctrl_decode #(.VARIANT(VARIANT)) u_dec (
    .word_addr (req_addr[ADDR_W-1:2]),
    .sel       (sel)
  );

  always_comb begin
    slot     = plain_slot(sel);
    slot_hit = (slot >= 0);
    slot_idx = SLOT_W'(slot_hit ? slot : 0);
  end

  // Plain stored words
  logic [DATA_W-1:0] plain_q [NUM_PLAIN];

  generate
    for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
      logic en_i;
      assign en_i = wr_en & slot_hit & (slot_idx == SLOT_W'(i));
      subsys_ctrl_word #(.W(DATA_W), .RST(plain_reset(i))) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_i),
        .d     (req_wdata),
        .q     (plain_q[i])
      );
    end
  endgenerate

  // Secure-debug enables: set/clear pair
  logic [DATA_W-1:0] dbg_q, dbg_d;
  always_comb begin
    dbg_d = dbg_q;
    if (wr_en && sel == SEL_DBG_SET) dbg_d = dbg_q |  req_wdata;
    if (wr_en && sel == SEL_DBG_CLR) dbg_d = dbg_q & ~req_wdata;
  end

  // Boot vectors (vector 0 lockable in variant C)
  logic [DATA_W-1:0] vec0_q, vec0_d, vec1_q, vec1_d;
  logic              vec0_locked;
  assign vec0_locked = IS_C & vec0_q[0];

  always_comb begin
    vec0_d = vec0_q;
    if (wr_en && sel == SEL_VEC0 && !vec0_locked) vec0_d = req_wdata;
    vec1_d = vec1_q;
    if (wr_en && sel == SEL_VEC1) vec1_d = req_wdata;
  end

  // Power control (variant C only, gated by its unlock bit)
  logic [DATA_W-1:0] pwr_q, pwr_d;
  always_comb begin
    pwr_d = pwr_q;
    if (wr_en && sel == SEL_PWR && pwr_q[0]) pwr_d = req_wdata;
  end

  // Software reset request
  logic swrst_d;
  assign swrst_d = wr_en & (sel == SEL_SWRST) & req_wdata[SWRST_BIT];

  // CPU hold word with release pulses
  logic [DATA_W-1:0] hold_q;
  logic              hold_wr;
  assign hold_wr = wr_en & (sel == SEL_HOLD);

  subsys_ctrl_hold #(
    .W(DATA_W), .NCPU(NUM_CPU), .NCHK(NCHK), .RST(HOLD_RST)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (hold_wr),
    .wdata     (req_wdata),
    .hold_q    (hold_q),
    .release_o (cpu_release)
  );

  // Read mux
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (slot_hit) rd_mux = plain_q[slot_idx];
    else begin
      case (sel)
        SEL_DBG_STAT: rd_mux = dbg_q;
        SEL_VEC0:     rd_mux = vec0_q;
        SEL_VEC1:     rd_mux = vec1_q;
        SEL_HOLD:     rd_mux = hold_q;
        SEL_PWR:      rd_mux = pwr_q;
        SEL_ID:       rd_mux = id_value(4'(req_addr[5:2] - 4'd4), VARIANT);
        default:      rd_mux = '0;
      endcase
    end
  end

  logic [DATA_W-1:0] rd_data_d;
  assign rd_data_d = rd_en ? rd_mux : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q        <= '0;
      vec0_q       <= BOOTVEC_RST;
      vec1_q       <= BOOTVEC_RST;
      pwr_q        <= PWR_RST;
      sw_reset_req <= 1'b0;
      rd_valid     <= 1'b0;
      rd_data      <= '0;
    end else begin
      dbg_q        <= dbg_d;
      vec0_q       <= vec0_d;
      vec1_q       <= vec1_d;
      pwr_q        <= pwr_d;
      sw_reset_req <= swrst_d;
      rd_valid     <= rd_en;
      rd_data      <= rd_data_d;
    end
  end

  assign boot_vec0 = IS_C ? {vec0_q[DATA_W-1:VEC_LOW], {VEC_LOW{1'b0}}} : vec0_q;
  assign boot_vec1 = vec1_q;

  AST_SWRST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_req |-> $past(wr_en && sel == SEL_SWRST && req_wdata[SWRST_BIT])); // R3
  AST_DBG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && sel == SEL_DBG_CLR) |-> ((dbg_q & $past(req_wdata)) == '0)); // R2
  AST_DBG_STAT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && sel == SEL_DBG_STAT) |-> $stable(dbg_q)); // R1
  AST_RD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en)); // R12

  generate
    if (IS_C) begin : g_lock_chk
      AST_VEC0_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vec0_q[0]) |-> $stable(vec0_q)); // R5
      AST_VEC0_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        boot_vec0[VEC_LOW-1:0] == '0); // R5
      AST_PWR_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pwr_q[0]) |-> $stable(pwr_q)); // R6
    end else begin : g_nopwr_chk
      AST_PWR_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && req_addr[ADDR_W-1:2] == 10'h07F) |-> $stable(pwr_q)); // R6
    end
  endgenerate

endmodule

// File: tb/sim_subsys_ctrl_regs.sv
`timescale 1ns/1ps
module sim_subsys_ctrl_regs;

  localparam int NV = 3;  // index 0 = variant A, 1 = B, 2 = C

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic        wrt = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wd = '0;

  logic        rv   [NV];
  logic [31:0] rdat [NV];
  logic        swr  [NV];
  logic [1:0]  rel  [NV];
  logic [31:0] bv0  [NV];
  logic [31:0] bv1  [NV];

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] expq [NV][$];
  string       tagq [NV][$];

  always #4 clk = ~clk;  // 125 MHz

  subsys_ctrl_regs #(.VARIANT(0), .HOLD_RST(32'h3)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(vld), .req_write(wrt), .req_addr(addr),
    .req_wdata(wd), .rd_valid(rv[0]), .rd_data(rdat[0]), .sw_reset_req(swr[0]),
    .cpu_release(rel[0]), .boot_vec0(bv0[0]), .boot_vec1(bv1[0]));
  subsys_ctrl_regs #(.VARIANT(1), .HOLD_RST(32'h3)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(vld), .req_write(wrt), .req_addr(addr),
    .req_wdata(wd), .rd_valid(rv[1]), .rd_data(rdat[1]), .sw_reset_req(swr[1]),
    .cpu_release(rel[1]), .boot_vec0(bv0[1]), .boot_vec1(bv1[1]));
  subsys_ctrl_regs #(.VARIANT(2), .HOLD_RST(32'h3)) u2 (
    .clk(clk), .rst_n(rst_n), .req_valid(vld), .req_write(wrt), .req_addr(addr),
    .req_wdata(wd), .rd_valid(rv[2]), .rd_data(rdat[2]), .sw_reset_req(swr[2]),
    .cpu_release(rel[2]), .boot_vec0(bv0[2]), .boot_vec1(bv1[2]));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    vld = 1'b1; wrt = 1'b1; addr = a; wd = d;
    @(negedge clk);
    vld = 1'b0; wrt = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] ea,
                    input logic [31:0] eb, input logic [31:0] ec, input string tag);
    @(negedge clk);
    expq[0].push_back(ea); tagq[0].push_back($sformatf("%s A @%h", tag, a));
    expq[1].push_back(eb); tagq[1].push_back($sformatf("%s B @%h", tag, a));
    expq[2].push_back(ec); tagq[2].push_back($sformatf("%s C @%h", tag, a));
    vld = 1'b1; wrt = 1'b0; addr = a;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic chk_pulses(input string tag, input logic [1:0] ea,
                            input logic [1:0] eb, input logic [1:0] ec, input logic esw);
    chk({tag, " rel A"}, {30'd0, rel[0]}, {30'd0, ea});
    chk({tag, " rel B"}, {30'd0, rel[1]}, {30'd0, eb});
    chk({tag, " rel C"}, {30'd0, rel[2]}, {30'd0, ec});
    for (int k = 0; k < NV; k++) chk({tag, " swrst"}, {31'd0, swr[k]}, {31'd0, esw});
  endtask

  // Monitor: compare read data against the scoreboard
  always @(negedge clk) begin
    #1;
    for (int k = 0; k < NV; k++) begin
      if (rv[k]) begin
        if (expq[k].size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R12 unexpected read data inst %0d actual=%h expected=none", k, rdat[k]);
        end else begin
          logic [31:0] e;
          string t;
          e = expq[k].pop_front();
          t = tagq[k].pop_front();
          chk(t, rdat[k], e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R4 reset state of outputs
    chk_pulses("R4 reset", 2'b00, 2'b00, 2'b00, 1'b0);
    for (int k = 0; k < NV; k++) begin
      chk("R4 boot_vec0 reset", bv0[k], 32'h1000_0000);
      chk("R4 boot_vec1 reset", bv1[k], 32'h1000_0000);
    end
    rst_n = 1'b1;
    // R4 reset values through reads
    rd(12'h000, 0, 0, 0, "R4 dbg");
    rd(12'h100, 1, 1, 1, "R4 cause");
    rd(12'h200, 0, 32'h7F, 32'h7F, "R4 sense sys");
    rd(12'h1FC, 0, 0, 3, "R4 pwr");
    rd(12'h110, 32'h1000_0000, 32'h1000_0000, 32'h1000_0000, "R4 vec0");
    rd(12'h114, 0, 32'h1000_0000, 0, "R4/R9 vec1");
    rd(12'h118, 3, 3, 0, "R4/R8 hold@118");
    rd(12'h120, 0, 0, 3, "R4/R8 word@120");
    rd(12'h10C, 0, 0, 0, "R4 retain");

    // R2 debug set/clear
    wr(12'h004, 32'h0000_00F0);
    rd(12'h000, 32'hF0, 32'hF0, 32'hF0, "R2 set");
    wr(12'h008, 32'h0000_0030);
    rd(12'h000, 32'hC0, 32'hC0, 32'hC0, "R2 clear");
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, 32'hC0, 32'hC0, 32'hC0, "R1 status read-only");
    rd(12'h004, 0, 0, 0, "R1 write-only set");
    rd(12'h008, 0, 0, 0, "R1 write-only clr");

    // R3 software reset
    wr(12'h108, 32'h0000_0100);
    chk_pulses("R3 bit9 clear", 2'b00, 2'b00, 2'b00, 1'b0);
    wr(12'h108, 32'h0000_0200);
    chk_pulses("R3 bit9 set", 2'b00, 2'b00, 2'b00, 1'b1);
    @(negedge clk);
    chk_pulses("R3 one cycle", 2'b00, 2'b00, 2'b00, 1'b0);
    rd(12'h108, 0, 0, 0, "R1/R3 swrst read");

    // R7/R8 hold and release
    wr(12'h118, 32'h1);
    chk_pulses("R7 drop cpu1 @118", 2'b10, 2'b10, 2'b00, 1'b0);
    @(negedge clk);
    chk_pulses("R7 pulse ends", 2'b00, 2'b00, 2'b00, 1'b0);
    wr(12'h120, 32'h4);
    chk_pulses("R7/R8 @120", 2'b00, 2'b00, 2'b01, 1'b0);
    wr(12'h118, 32'h0);
    chk_pulses("R7 drop cpu0 @118", 2'b01, 2'b01, 2'b00, 1'b0);
    rd(12'h118, 0, 0, 0, "R8 hold@118");
    rd(12'h120, 4, 4, 4, "R8 word@120");

    // R8/R9 NMI placement
    wr(12'h11C, 32'hA5);
    wr(12'h124, 32'h5A);
    rd(12'h11C, 0, 32'hA5, 0, "R8/R9 @11C");
    rd(12'h124, 0, 32'h5A, 32'h5A, "R8/R9 @124");

    // R9 words absent in variant A, vec1 only in B
    wr(12'h00C, 32'h11);
    wr(12'h010, 32'h22);
    wr(12'h114, 32'h2000_0080);
    rd(12'h00C, 0, 32'h11, 32'h11, "R9 @00C");
    rd(12'h010, 0, 32'h22, 32'h22, "R9 @010");
    rd(12'h114, 0, 32'h2000_0080, 0, "R9 vec1");
    chk("R9 boot_vec1 A", bv1[0], 32'h1000_0000);
    chk("R9 boot_vec1 B", bv1[1], 32'h2000_0080);
    chk("R9 boot_vec1 C", bv1[2], 32'h1000_0000);

    // R5 boot vector 0 lock and masking
    wr(12'h110, 32'h2000_00FE);
    chk("R5 vec0 A", bv0[0], 32'h2000_00FE);
    chk("R5 vec0 C masked", bv0[2], 32'h2000_0080);
    wr(12'h110, 32'h3000_00FF);
    chk("R5 vec0 C lock write", bv0[2], 32'h3000_0080);
    wr(12'h110, 32'h4000_0000);
    chk("R5 vec0 B after lock", bv0[1], 32'h4000_0000);
    chk("R5 vec0 C locked", bv0[2], 32'h3000_0080);
    rd(12'h110, 32'h4000_0000, 32'h4000_0000, 32'h3000_00FF, "R5 vec0 read");

    // R6 power control
    wr(12'h1FC, 32'h2);
    wr(12'h1FC, 32'h3);
    rd(12'h1FC, 0, 0, 2, "R6 pwr lock");

    // R11 sense words
    wr(12'h204, 32'h44);
    wr(12'h20C, 32'h55);
    wr(12'h218, 32'h66);
    wr(12'h200, 32'h11);
    rd(12'h204, 0, 0, 32'h44, "R11 @204");
    rd(12'h20C, 0, 32'h55, 0, "R11 @20C");
    rd(12'h218, 0, 32'h66, 32'h66, "R11 @218");
    rd(12'h200, 0, 32'h11, 32'h11, "R11 @200");

    // R10 identification block
    for (int i = 0; i < 12; i++) begin
      logic [31:0] e;
      case (i)
        0: e = 32'h04; 4: e = 32'h54; 5: e = 32'hB8; 6: e = 32'h1B;
        8: e = 32'h0D; 9: e = 32'hF0; 10: e = 32'h05; 11: e = 32'hB1;
        default: e = 32'h00;
      endcase
      rd(12'hFD0 + 12'(i * 4), (i == 6) ? 32'h0B : e, e, e, "R10 id");
    end

    // R12 unaligned access, R1 unmapped and read-only writes
    rd(12'hFE2, 32'h54, 32'h54, 32'h54, "R12 unaligned read");
    wr(12'h10E, 32'h0000_DEAD);
    rd(12'h10C, 32'hDEAD, 32'hDEAD, 32'hDEAD, "R12 unaligned write");
    wr(12'h104, 32'h0000_0F0F);
    rd(12'h104, 32'hF0F, 32'hF0F, 32'hF0F, "R4 reset mask rw");
    wr(12'h300, 32'h1234_5678);
    rd(12'h300, 0, 0, 0, "R1 unmapped");
    wr(12'hFE0, 32'hFF);
    rd(12'hFE0, 32'h54, 32'h54, 32'h54, "R1 id read-only");

    repeat (4) @(negedge clk);
    for (int k = 0; k < NV; k++)
      chk("R12 pending reads", 32'(expq[k].size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule